// File: doc/BRIEF.md
# Serial EEPROM Byte Reader

This block fetches single bytes from an external two-wire serial EEPROM on behalf of a host-visible access register. Software sets a command bit, and the block runs a complete random-address read on the wire. That read is a start condition, the device code with the write direction, the word address, a repeated start, the device code with the read direction, eight data bits, a master no-acknowledge and a stop condition. The fetched byte then appears in the register.

The block keeps its own byte address. The address steps forward by one after every acknowledged read, so successive commands walk through the ROM. Software can return the address to zero with a self-clearing command bit. A presence flag shows whether the ROM acknowledged the last attempt. A read that gets no acknowledge returns FFh. The serial clock comes from the system clock through a divider: each quarter of a bit period lasts `DIV` system cycles.

Top module: `sprom_reader`

## Requirements
- R1: After reset the access register reads 00000000h, `scl` is high and `sda_oe` is low (line released).
- R2: A write with bit 31 set makes bit 31 read 1 and later 0. When it clears, the byte address is zero. If a read is in progress, the clearing waits until that read ends, and the read in progress still uses the old address.
- R3: A write with bit 25 set starts a read, and bit 25 reads 1 until the read ends. With an acknowledging ROM, bit 25 reads 1 for 1+156*DIV cycles. If the device code gets no acknowledge, it reads 1 for 1+44*DIV cycles.
- R4: Once bit 25 reads 0, bits 7:0 hold the byte stored at the address the read used.
- R5: After each acknowledged read, the byte address rises by one and wraps from 2^ADDR_W-1 to 0. A read without acknowledge leaves the address unchanged.
- R6: A successful read frame has exactly two start conditions and one stop condition. It sends device code 1010000 with direction 0 and then 1, and the word address it sends is the current byte address, zero-extended to 8 bits.
- R7: The ROM acknowledges in the ninth clock of each byte it receives, by holding the line low. If that acknowledge is missing, the transfer ends at once with a stop condition, bits 7:0 read FFh and bit 8 reads 0.
- R8: Bit 8 (presence) reads 1 after an acknowledged read.
- R9: Bits 30:26, bit 24 and bits 23:9 always read 0.
- R10: Outside start and stop conditions, `sda_oe` changes only while `scl` is low in both the current and the previous cycle. While no read is running, the bus is idle: `scl` is high and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the access register |
| reg_wdata | input | 32 | Write data (bit 31 address reset, bit 25 read start) |
| reg_rdata | output | 32 | Access register read value |
| scl | output | 1 | Serial clock to the EEPROM |
| sda_oe | output | 1 | Pulls the open-drain data line low when 1 |
| sda_i | input | 1 | Sensed level of the data line |

## Verification
A wrong step counter or a wrong quarter-phase count shows up as a wrong bit-25 high time in the same read. It also shows up as a frame the responder cannot decode, so the returned byte no longer matches the expected byte. An address counter that slips surfaces on the next read, as data taken from the wrong location or as a wrong word address seen by the responder. A lost acknowledge decision shows up within one read, as wrong presence, wrong FFh data, or a too-short or too-long frame.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  typedef enum logic [2:0] {
    SEG_START, SEG_TX, SEG_ACKIN, SEG_RX, SEG_NACK, SEG_STOP
  } seg_e;

  localparam int FLD_ARST = 31;
  localparam int FLD_RGO  = 25;
  localparam int FLD_PRES = 8;
  localparam logic [5:0] STP_LAST = 6'd38;

  // Segment kind of each step in the read frame
  function automatic seg_e seg_of(input logic [5:0] step);
    if (step == 6'd0 || step == 6'd19)                     return SEG_START;
    if (step == 6'd9 || step == 6'd18 || step == 6'd28)   return SEG_ACKIN;
    if (step >= 6'd29 && step <= 6'd36)                    return SEG_RX;
    if (step == 6'd37)                                     return SEG_NACK;
    if (step == STP_LAST)                                  return SEG_STOP;
    return SEG_TX;
  endfunction

  // Bit sent in a transmit step, MSB first
  function automatic logic tx_bit(input logic [5:0] step, input logic [6:0] dev,
                                  input logic [7:0] word);
    logic [7:0] b;
    logic [2:0] idx;
    if (step <= 6'd8) begin
      b = {dev, 1'b0}; idx = 3'(step - 6'd1);
    end else if (step <= 6'd17) begin
      b = word;        idx = 3'(step - 6'd10);
    end else begin
      b = {dev, 1'b1}; idx = 3'(step - 6'd20);
    end
    return b[3'd7 - idx];
  endfunction

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || tick)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sprom_addr.sv
module sprom_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (inc)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/sprom_bitseq.sv
module sprom_bitseq
  import sprom_pkg::*;
#(
  parameter logic [6:0] DEV = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic [7:0] word,
  input  logic       sda_i,
  output logic       busy,
  output logic       scl,
  output logic       sda_oe,
  output logic       cond_phase,
  output logic       fin,
  output logic       ack_fail,
  output logic [7:0] rx_byte
);
  logic       run;
  logic [5:0] step;
  logic [1:0] q;
  logic       nack;
  logic [7:0] sh;
  seg_e       seg;

  assign seg      = seg_of(step);
  assign fin      = tick && run && (q == 2'd3) && (step == STP_LAST);
  assign busy     = run;
  assign ack_fail = nack;
  assign rx_byte  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; step <= '0; q <= '0; nack <= 1'b0; sh <= '0;
    end else if (start && !run) begin
      run <= 1'b1; step <= '0; q <= '0; nack <= 1'b0;
    end else if (tick && run) begin
      q <= q + 1'b1;
      if (q == 2'd1) begin
        if (seg == SEG_ACKIN && sda_i) nack <= 1'b1;
        if (seg == SEG_RX)             sh   <= {sh[6:0], sda_i};
      end
      if (q == 2'd3) begin
        if (step == STP_LAST)                 run  <= 1'b0;
        else if (seg == SEG_ACKIN && nack)    step <= STP_LAST;
        else                                  step <= step + 1'b1;
      end
    end
  end

  // Line levels per quarter: clock high in quarters 1 and 2
  always_comb begin
    scl        = 1'b1;
    sda_oe     = 1'b0;
    cond_phase = 1'b0;
    if (run) begin
      scl = (q == 2'd1) || (q == 2'd2);
      case (seg)
        SEG_START: begin cond_phase = 1'b1; sda_oe = q[1]; end
        SEG_TX:    sda_oe = !tx_bit(step, DEV, word);
        SEG_STOP:  begin cond_phase = 1'b1; scl = (q != 2'd0); sda_oe = !q[1]; end
        default:   sda_oe = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sprom_reader.sv
module sprom_reader
  import sprom_pkg::*;
#(
  parameter int         DIV    = 4,
  parameter int         ADDR_W = 8,
  parameter logic [6:0] DEV    = 7'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl,
  output logic        sda_oe,
  input  logic        sda_i
);
  logic              arst_pend, rd_go, present;
  logic [7:0]        data_q;
  logic [ADDR_W-1:0] addr;
  logic              busy, tick, fin, ack_fail, cond_phase, start;
  logic [7:0]        rx_byte;
  logic              addr_clr;

  assign addr_clr = arst_pend && !busy;
  assign start    = rd_go && !arst_pend && !busy;

  sprom_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  sprom_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(fin && !ack_fail), .addr(addr)
  );

  sprom_bitseq #(.DEV(DEV)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .word(8'(addr)),
    .sda_i(sda_i), .busy(busy), .scl(scl), .sda_oe(sda_oe),
    .cond_phase(cond_phase), .fin(fin), .ack_fail(ack_fail), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arst_pend <= 1'b0; rd_go <= 1'b0; present <= 1'b0; data_q <= '0;
    end else begin
      if (addr_clr) arst_pend <= 1'b0;
      if (fin) begin
        rd_go   <= 1'b0;
        present <= !ack_fail;
        data_q  <= ack_fail ? 8'hFF : rx_byte;
      end
      if (reg_wr) begin
        if (reg_wdata[FLD_ARST]) arst_pend <= 1'b1;
        if (reg_wdata[FLD_RGO])  rd_go     <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[FLD_ARST] = arst_pend;
    reg_rdata[FLD_RGO]  = rd_go;
    reg_rdata[FLD_PRES] = present;
    reg_rdata[7:0]      = data_q;
  end
endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [31:0]       reg_rdata,
  input logic              scl,
  input logic              sda_oe,
  input logic              busy,
  input logic              cond_phase,
  input logic              fin,
  input logic              ack_fail,
  input logic [ADDR_W-1:0] addr
);
  p_data_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cond_phase && !$stable(sda_oe)) |-> (!scl && !$past(scl)));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && !sda_oe));

  p_go_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !reg_wr) |=> !reg_rdata[25]);

  p_nack_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ack_fail) |=> (!reg_rdata[8] && reg_rdata[7:0] == 8'hFF));

  p_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ack_fail) |=> reg_rdata[8]);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ack_fail) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

  p_pend_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31] && !busy && !reg_wr) |=> !reg_rdata[31]);

  p_zero_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[31]) |-> (addr == '0));
endmodule

bind sprom_reader sprom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .scl(scl), .sda_oe(sda_oe), .busy(busy), .cond_phase(cond_phase),
  .fin(fin), .ack_fail(ack_fail), .addr(addr)
);

// File: tb/tb_sprom_reader.sv
module tb_sprom_reader;
  localparam int DIV = 4;
  localparam int AW  = 4;

  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        scl, sda_oe;
  wire         sda_i;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // open-drain line with an EEPROM responder
  logic slv_low = 0, rom_here = 1;
  wire  sda_line = !(sda_oe | slv_low);
  assign sda_i = sda_line;

  sprom_reader #(.DIV(DIV), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl(scl), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'd29) ^ 8'hA5;
  endfunction

  int cnt = 0, byte_i = 0, n_start = 0, n_stop = 0;
  logic rd_mode = 0, sending = 0, go_send = 0;
  logic [7:0] sh_s = 0, ptr = 0, tx_d = 0, last_ptr = 0;

  always @(negedge sda_line) if (scl === 1'b1) begin
    n_start++; cnt = 0; byte_i = 0; sending = 0; go_send = 0; slv_low = 0;
  end
  always @(posedge sda_line) if (scl === 1'b1 && rst_n) begin
    n_stop++; cnt = 0; sending = 0; go_send = 0; slv_low = 0;
  end
  always @(posedge scl) begin
    if (!sending && cnt < 8) sh_s = {sh_s[6:0], sda_line};
    cnt++;
  end
  always @(negedge scl) begin
    if (cnt == 8) begin
      if (sending) slv_low = 0;
      else begin
        if (byte_i == 0) begin
          if (rom_here && sh_s[7:1] == 7'h50) begin
            slv_low = 1; rd_mode = sh_s[0]; go_send = sh_s[0];
          end
        end else if (!rd_mode) begin
          ptr = sh_s; last_ptr = sh_s; slv_low = 1;
        end
        byte_i++;
      end
    end else if (cnt == 9) begin
      cnt = 0; slv_low = 0;
      if (go_send) begin go_send = 0; sending = 1; tx_d = pat(ptr); slv_low = !tx_d[7]; end
      else sending = 0;
    end else if (sending && cnt >= 1 && cnt <= 7) begin
      slv_low = !tx_d[7-cnt];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  logic [AW-1:0] exp_addr = 0;

  task automatic do_read();
    int cyc = 0;
    int want;
    logic [7:0] ed;
    n_start = 0; n_stop = 0;
    wr(32'h0200_0000);
    while (reg_rdata[25] === 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
    want = rom_here ? 1 + 156*DIV : 1 + 44*DIV;
    chk(cyc == want, "R3 read-start duration", cyc, want);
    chk((reg_rdata & ~32'h8200_01FF) == 0, "R9 unused bits", reg_rdata, reg_rdata & 32'h8200_01FF);
    chk(scl === 1'b1 && sda_oe === 1'b0, "R10 idle bus", {scl, sda_oe}, 2'b10);
    if (rom_here) begin
      ed = pat(8'(exp_addr));
      chk(reg_rdata[7:0] == ed, "R4 read data", reg_rdata[7:0], ed);
      chk(reg_rdata[8] == 1'b1, "R8 presence", reg_rdata[8], 1);
      chk(last_ptr == 8'(exp_addr) && n_start == 2 && n_stop == 1, "R6 frame",
          {last_ptr, 8'(n_start), 8'(n_stop)}, {8'(exp_addr), 8'd2, 8'd1});
      exp_addr = exp_addr + 1'b1;
    end else begin
      chk(reg_rdata[8:0] == 9'h0FF, "R7 missing ack", reg_rdata[8:0], 9'h0FF);
      chk(n_start == 1 && n_stop == 1, "R7 early stop", {n_start[7:0], n_stop[7:0]}, 16'h0101);
    end
  endtask

  task automatic addr_reset();
    wr(32'h8000_0000);
    chk(reg_rdata[31] == 1'b1, "R2 bit set", reg_rdata[31], 1);
    @(negedge clk);
    chk(reg_rdata[31] == 1'b0, "R2 bit cleared", reg_rdata[31], 0);
    exp_addr = 0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=completion");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(reg_rdata == 0 && scl === 1'b1 && sda_oe === 1'b0, "R1 reset state",
        reg_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    do_read();            // address 0
    do_read();            // address 1, R5 increment
    rom_here = 0;
    do_read();            // R7, address must stay
    rom_here = 1;
    do_read();            // R5 unchanged after failed read: address 2
    addr_reset();
    do_read();            // R2: back to address 0

    // deferred reset during a read (R2)
    begin
      logic [7:0] ed;
      ed = pat(8'(exp_addr));
      wr(32'h0200_0000);
      repeat (10) @(negedge clk);
      wr(32'h8000_0000);
      chk(reg_rdata[31] && reg_rdata[25], "R2 pending during read", reg_rdata, 32'h8200_0000);
      while (reg_rdata[31] || reg_rdata[25]) @(negedge clk);
      chk(reg_rdata[7:0] == ed, "R2 read uses old address", reg_rdata[7:0], ed);
      exp_addr = 0;
      do_read();
    end

    // wrap across 2^AW (R5)
    addr_reset();
    for (int i = 0; i < (1 << AW) + 1; i++) do_read();

    // random mix
    for (int i = 0; i < 20; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 7)       do_read();
      else if (r == 7) addr_reset();
      else             rom_here = !rom_here;
    end
    rom_here = 1;
    do_read();

    done = 1;
    finish_up();
  end
endmodule